// File: doc/BRIEF.md
# Double-Precision Funnel Shift Unit

This block shifts a 32-bit destination operand left or right by a count of 0 to 31. The bit positions that the shift empties are filled from a second 32-bit source operand rather than with zeros, so the pair behaves as one 64-bit value from which a 32-bit window is taken. Alongside the result, the unit produces the carry, overflow, sign, zero, parity and auxiliary-carry flags under the integer instruction rules. The carry and overflow rules differ between the two directions. Each flag comes with its own update enable.

The count comes from one of two bytes, a register byte or an immediate byte. Only its low five bits are used. A masked count of zero leaves the destination and all flags unchanged. In register form the 64-bit container's upper half is still cleared. Results are registered, and each accepted operation appears for exactly one cycle on `out_valid`, one cycle after `in_valid`.

Control is a two-state machine. ST_IDLE means no result is presented. ST_EMIT means a result is presented this cycle. The transition "accept" (ST_IDLE to ST_EMIT) and the transition "repeat" (ST_EMIT to ST_EMIT) both happen when `in_valid` is high. The transition "drain" (ST_EMIT to ST_IDLE) happens when `in_valid` is low, and ST_IDLE stays in ST_IDLE on the same condition.

Top module: `fsh_unit`

## Requirements
- R1: The count is `imm_cnt` when `cnt_use_imm` is 1 and `reg_cnt` when it is 0. Only the low 5 bits of the chosen byte are used; bits 7:5 have no effect.
- R2: With `dir_right` = 0 and masked count n in 1..31, the result is (dst << n) | (src >> (32 - n)).
- R3: With `dir_right` = 1 and masked count n in 1..31, the result is (src << (32 - n)) | (dst >> n).
- R4: For a left shift, carry equals dst bit (32 - n), which is the last bit pushed out. Overflow equals carry XOR result bit 31.
- R5: For a right shift, carry equals dst bit (n - 1). Overflow equals result bit 31 XOR result bit 30.
- R6: Sign is result bit 31. Zero is 1 exactly when the result is 0. Parity is 1 when the low 8 result bits hold an even number of ones. Auxiliary carry is 0.
- R7: When the masked count is 0, `res_we` is 0 and `flag_we` is all zeros.
- R8: `upper_clr` is 1 together with `out_valid` for every register-form operation (`mem_form` = 0), including a zero count. It is never 1 for memory form.
- R9: `out_valid` is 1 in the cycle after each cycle with `in_valid` = 1, and 0 otherwise. Back-to-back inputs give back-to-back results. `res_we` and `flag_we` are 0 whenever `out_valid` is 0.
- R10: `flags_out` and `flag_we` share one bit order: 0 carry, 1 parity, 2 auxiliary carry, 3 zero, 4 sign, 5 overflow. For a nonzero count, `flag_we` is 6'b111111 and `res_we` is 1.
- R11: While reset is held, `out_valid`, `res_we`, `upper_clr` and `flag_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| dir_right | input | 1 | 1 shifts right, 0 shifts left |
| cnt_use_imm | input | 1 | 1 takes the count from imm_cnt, 0 from reg_cnt |
| reg_cnt | input | 8 | Count byte from a register |
| imm_cnt | input | 8 | Count byte from an immediate |
| mem_form | input | 1 | 1 when the destination is in memory |
| dst_in | input | 32 | Destination operand |
| src_in | input | 32 | Fill source operand |
| out_valid | output | 1 | Result presented this cycle |
| res_out | output | 32 | Shifted result |
| res_we | output | 1 | Destination write enable |
| upper_clr | output | 1 | Clear the upper half of the 64-bit register |
| flags_out | output | 6 | Flag values, in R10 order |
| flag_we | output | 6 | Per-flag update enables, in R10 order |

## Verification
Both directions are driven with counts of 1, an interior value and 31. A count of 1 and a count of 31 take nearly all result bits from opposite operands, so a swapped fill operand or an off-by-one in the fill amount shows up at once. The carry checks use operands whose neighbouring bits differ, which separates dst bit (32 - n) or dst bit (n - 1) from the bits next to them. Results with high bits 31:30 equal and results with them different separate the two overflow rules. Counts with upper bits set, with the two count bytes differing, and a count of 32 that masks to zero show that the count is masked and that the right source is chosen. Register form and memory form, and a back-to-back pair, exercise the clear strobe and the one-cycle timing.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
    localparam int unsigned FLAG_N = 6;
    localparam int unsigned FI_CF  = 0;
    localparam int unsigned FI_PF  = 1;
    localparam int unsigned FI_AF  = 2;
    localparam int unsigned FI_ZF  = 3;
    localparam int unsigned FI_SF  = 4;
    localparam int unsigned FI_OF  = 5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fsh_state_e;
endpackage

// File: rtl/fsh_count_sel.sv
module fsh_count_sel #(
    parameter int unsigned IN_W = 8,
    parameter int unsigned CW   = 5
) (
    input  logic            use_imm,
    input  logic [IN_W-1:0] reg_cnt,
    input  logic [IN_W-1:0] imm_cnt,
    output logic [CW-1:0]   cnt,
    output logic            cnt_nz
);
    logic [IN_W-1:0] chosen;

    always_comb begin
        chosen = use_imm ? imm_cnt : reg_cnt;
        cnt    = chosen[CW-1:0];
        cnt_nz = |cnt;
    end
endmodule

// File: rtl/fsh_datapath.sv
module fsh_datapath
    import fsh_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic              dir_right,
    input  logic [W-1:0]      dst,
    input  logic [W-1:0]      src,
    input  logic [CW-1:0]     cnt,
    output logic [W-1:0]      res,
    output logic [FLAG_N-1:0] flags
);
    localparam int unsigned WW = 2 * W + 1;

    logic [WW-1:0] lwin;
    logic [WW-1:0] rwin;
    logic [W-1:0]  res_l;
    logic [W-1:0]  res_r;
    logic          cf_l;
    logic          cf_r;

    always_comb begin
        // Left: guard bit above dst catches the last bit pushed out.
        lwin  = {1'b0, dst, src} << cnt;
        res_l = lwin[2*W-1:W];
        cf_l  = lwin[2*W];
        // Right: guard bit below dst catches the last bit pushed out.
        rwin  = {src, dst, 1'b0} >> cnt;
        res_r = rwin[W:1];
        cf_r  = rwin[0];

        res   = dir_right ? res_r : res_l;
        flags = '0;
        flags[FI_CF] = dir_right ? cf_r : cf_l;
        flags[FI_OF] = dir_right ? (res_r[W-1] ^ res_r[W-2]) : (cf_l ^ res_l[W-1]);
        flags[FI_SF] = res[W-1];
        flags[FI_ZF] = (res == '0);
        flags[FI_PF] = ~^res[7:0];
        flags[FI_AF] = 1'b0;
    end
endmodule

// File: rtl/fsh_ctrl.sv
module fsh_ctrl
    import fsh_pkg::*;
#(
    parameter int unsigned NF = FLAG_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          nz_q,
    input  logic          regform_q,
    output logic          out_valid,
    output logic          res_we,
    output logic          upper_clr,
    output logic [NF-1:0] flag_we
);
    fsh_state_e state_q;
    fsh_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        out_valid = 1'b0;
        res_we    = 1'b0;
        upper_clr = 1'b0;
        flag_we   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EMIT: begin
                out_valid = 1'b1;
                res_we    = nz_q;
                upper_clr = regform_q;
                flag_we   = {NF{nz_q}};
            end
            default: ;
        endcase
    end

    p_emit_after_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_after_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_we_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!res_we && flag_we == '0));
    p_clr_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upper_clr |-> out_valid);
endmodule

// File: rtl/fsh_unit.sv
module fsh_unit
    import fsh_pkg::*;
#(
    parameter int unsigned W    = 32,
    parameter int unsigned IN_W = 8,
    parameter int unsigned CW   = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dir_right,
    input  logic              cnt_use_imm,
    input  logic [IN_W-1:0]   reg_cnt,
    input  logic [IN_W-1:0]   imm_cnt,
    input  logic              mem_form,
    input  logic [W-1:0]      dst_in,
    input  logic [W-1:0]      src_in,
    output logic              out_valid,
    output logic [W-1:0]      res_out,
    output logic              res_we,
    output logic              upper_clr,
    output logic [FLAG_N-1:0] flags_out,
    output logic [FLAG_N-1:0] flag_we
);
    logic [CW-1:0]     cnt;
    logic              cnt_nz;
    logic [W-1:0]      res_c;
    logic [FLAG_N-1:0] flags_c;
    logic              nz_q;
    logic              regform_q;

    fsh_count_sel #(.IN_W(IN_W), .CW(CW)) u_cnt (
        .use_imm (cnt_use_imm),
        .reg_cnt (reg_cnt),
        .imm_cnt (imm_cnt),
        .cnt     (cnt),
        .cnt_nz  (cnt_nz)
    );

    fsh_datapath #(.W(W), .CW(CW)) u_dp (
        .dir_right (dir_right),
        .dst       (dst_in),
        .src       (src_in),
        .cnt       (cnt),
        .res       (res_c),
        .flags     (flags_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_out   <= '0;
            flags_out <= '0;
            nz_q      <= 1'b0;
            regform_q <= 1'b0;
        end else if (in_valid) begin
            res_out   <= res_c;
            flags_out <= flags_c;
            nz_q      <= cnt_nz;
            regform_q <= !mem_form;
        end
    end

    fsh_ctrl #(.NF(FLAG_N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .nz_q      (nz_q),
        .regform_q (regform_q),
        .out_valid (out_valid),
        .res_we    (res_we),
        .upper_clr (upper_clr),
        .flag_we   (flag_we)
    );

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (flags_out[FI_ZF] == (res_out == '0)));
    p_sign_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (flags_out[FI_SF] == res_out[W-1]));
    p_af_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> !flags_out[FI_AF]);
    p_we_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((flag_we != '0) == res_we));
    p_right_of_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_right && cnt_nz) |=>
            (flags_out[FI_OF] == (res_out[W-1] ^ res_out[W-2])));
endmodule

// File: tb/fsh_unit_bench.sv
module fsh_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, dir_right, cnt_use_imm, mem_form;
    logic [7:0]  reg_cnt, imm_cnt;
    logic [31:0] dst_in, src_in;
    logic        out_valid, res_we, upper_clr;
    logic [31:0] res_out;
    logic [5:0]  flags_out, flag_we;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fsh_unit u_fsh_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_right(dir_right),
        .cnt_use_imm(cnt_use_imm), .reg_cnt(reg_cnt), .imm_cnt(imm_cnt),
        .mem_form(mem_form), .dst_in(dst_in), .src_in(src_in),
        .out_valid(out_valid), .res_out(res_out), .res_we(res_we),
        .upper_clr(upper_clr), .flags_out(flags_out), .flag_we(flag_we)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bit-serial reference: one bit per step, built from the requirements.
    task automatic model(input logic right, input logic [31:0] d, input logic [31:0] s,
                         input int n, output logic [31:0] r, output logic [5:0] f);
        logic [31:0] a;
        logic [31:0] b;
        logic c;
        logic ovf;
        a = d; b = s; c = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (!right) begin
                c = a[31]; a = {a[30:0], b[31]}; b = {b[30:0], 1'b0};
            end else begin
                c = a[0];  a = {b[0], a[31:1]};  b = {1'b0, b[31:1]};
            end
        end
        ovf = right ? (a[31] ^ a[30]) : (c ^ a[31]);
        r = a;
        f = {ovf, a[31], (a == 32'h0), 1'b0, ~^a[7:0], c};
    endtask

    task automatic drive(input logic right, input logic imm, input logic [7:0] rc,
                         input logic [7:0] ic, input logic mem,
                         input logic [31:0] d, input logic [31:0] s);
        in_valid = 1'b1; dir_right = right; cnt_use_imm = imm;
        reg_cnt = rc; imm_cnt = ic; mem_form = mem; dst_in = d; src_in = s;
    endtask

    task automatic expect_out(input string tag, input logic right, input int n,
                              input logic mem, input logic [31:0] d, input logic [31:0] s);
        logic [31:0] r;
        logic [5:0]  f;
        model(right, d, s, n, r, f);
        chk({tag, " R9 out_valid"}, 64'(out_valid), 64'd1);
        chk({tag, " R8 upper_clr"}, 64'(upper_clr), 64'(!mem));
        if (n == 0) begin
            chk({tag, " R7 res_we"},  64'(res_we),  64'd0);
            chk({tag, " R7 flag_we"}, 64'(flag_we), 64'd0);
        end else begin
            chk({tag, " R10 res_we"},  64'(res_we),  64'd1);
            chk({tag, " R10 flag_we"}, 64'(flag_we), 64'h3f);
            chk({tag, right ? " R3 result" : " R2 result"}, 64'(res_out), 64'(r));
            chk({tag, right ? " R5 carry" : " R4 carry"}, 64'(flags_out[0]), 64'(f[0]));
            chk({tag, right ? " R5 overflow" : " R4 overflow"}, 64'(flags_out[5]), 64'(f[5]));
            chk({tag, " R6 sf/zf/af/pf"}, 64'(flags_out[4:1]), 64'(f[4:1]));
        end
    endtask

    task automatic one_op(input string tag, input logic right, input logic imm,
                          input logic [7:0] rc, input logic [7:0] ic, input logic mem,
                          input logic [31:0] d, input logic [31:0] s);
        @(negedge clk);
        drive(right, imm, rc, ic, mem, d, s);
        @(negedge clk);
        in_valid = 1'b0;
        expect_out(tag, right, int'((imm ? ic : rc) & 8'h1f), mem, d, s);
        @(negedge clk);
        chk({tag, " R9 single pulse"}, 64'(out_valid), 64'd0);
    endtask

    task automatic t_reset;
        in_valid = 1'b0; dir_right = 1'b0; cnt_use_imm = 1'b0; mem_form = 1'b0;
        reg_cnt = '0; imm_cnt = '0; dst_in = '0; src_in = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 out_valid", 64'(out_valid), 64'd0);
        chk("R11 res_we",    64'(res_we),    64'd0);
        chk("R11 upper_clr", 64'(upper_clr), 64'd0);
        chk("R11 flag_we",   64'(flag_we),   64'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_left;
        one_op("left n1",  1'b0, 1'b0, 8'd1,  8'd0, 1'b0, 32'h4000_0001, 32'h8000_0000);
        one_op("left n4",  1'b0, 1'b0, 8'd4,  8'd0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0);
        one_op("left n31", 1'b0, 1'b0, 8'd31, 8'd0, 1'b0, 32'h0000_0002, 32'hFFFF_FFFE);
        one_op("left zero result", 1'b0, 1'b0, 8'd16, 8'd0, 1'b0, 32'h8000_0000, 32'h0000_FFFF);
    endtask

    task automatic t_right;
        one_op("right n1",  1'b1, 1'b0, 8'd1,  8'd0, 1'b0, 32'h0000_0003, 32'h0000_0000);
        one_op("right n8",  1'b1, 1'b0, 8'd8,  8'd0, 1'b0, 32'hDEAD_BEEF, 32'h0000_00A5);
        one_op("right n31", 1'b1, 1'b0, 8'd31, 8'd0, 1'b0, 32'h4000_0000, 32'h2AAA_AAAA);
        one_op("right ovf", 1'b1, 1'b0, 8'd2,  8'd0, 1'b0, 32'h0000_0002, 32'h0000_0002);
    endtask

    task automatic t_count_select;
        one_op("R1 imm chosen",  1'b0, 1'b1, 8'd3, 8'd9, 1'b0, 32'hA5A5_0F0F, 32'h1357_9BDF);
        one_op("R1 reg chosen",  1'b1, 1'b0, 8'd3, 8'd9, 1'b0, 32'hA5A5_0F0F, 32'h1357_9BDF);
        one_op("R1 mask 0x27",   1'b0, 1'b1, 8'd0, 8'h27, 1'b0, 32'hCAFE_F00D, 32'h0BAD_F00D);
        one_op("R1 mask 0xE5",   1'b1, 1'b0, 8'hE5, 8'd1, 1'b0, 32'hCAFE_F00D, 32'h0BAD_F00D);
    endtask

    task automatic t_zero_count;
        one_op("R7 count 32 reg",  1'b0, 1'b0, 8'd32, 8'd5, 1'b0, 32'h1111_2222, 32'h3333_4444);
        one_op("R7 count 0 mem",   1'b1, 1'b1, 8'd5,  8'd0, 1'b1, 32'h1111_2222, 32'h3333_4444);
    endtask

    task automatic t_mem_form;
        one_op("R8 mem nonzero", 1'b0, 1'b0, 8'd7, 8'd0, 1'b1, 32'h0F0F_0F0F, 32'hF0F0_F0F0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        drive(1'b0, 1'b0, 8'd5, 8'd0, 1'b0, 32'h89AB_CDEF, 32'h0123_4567);
        @(negedge clk);
        expect_out("R9 pair first", 1'b0, 5, 1'b0, 32'h89AB_CDEF, 32'h0123_4567);
        drive(1'b1, 1'b1, 8'd0, 8'd12, 1'b1, 32'h7654_3210, 32'hFEDC_BA98);
        @(negedge clk);
        in_valid = 1'b0;
        expect_out("R9 pair second", 1'b1, 12, 1'b1, 32'h7654_3210, 32'hFEDC_BA98);
        @(negedge clk);
        chk("R9 idle after pair", 64'(out_valid), 64'd0);
        chk("R9 no write idle",   64'(res_we),    64'd0);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_left();
        t_right();
        t_count_select();
        t_zero_count();
        t_mem_form();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule